// File: doc/BRIEF.md
# Temperature Window Alarm

This block watches a stream of finished 12-bit temperature codes and raises an alarm when a code leaves a programmable band. Each code comes with a one-cycle valid strobe from the conversion sequencer. Software programs a floor and a ceiling for the band, a compare-enable gate and an interrupt-enable gate through a simple write port. It then removes the alarm by writing one to a clear register.

An excursion is judged only when a new code arrives while comparison is enabled. A code below the floor or above the ceiling sets a sticky alarm flag. The flag stays set until software clears it. The interrupt line is the flag gated by its enable bit, taken through a register so that it cannot glitch.

Top module: `thermwin_top`

## Requirements
- R1: After reset the alarm flag and the interrupt line are 0, comparison and interrupt are disabled, the floor is 0 and the ceiling is all ones, so no code is outside the band.
- R2: On a clock edge where the valid strobe is high, comparison is enabled and the code is strictly below the floor or strictly above the ceiling, the flag reads 1 after that edge. A code equal to the floor or to the ceiling does not set it.
- R3: The flag is not set when the valid strobe is low, or when bit 0 of the mode register (write select 2) is 0.
- R4: Once set, the flag stays at 1 until a write to select 4 has bit 1 set. After that edge it reads 0.
- R5: The interrupt line equals the flag ANDed with bit 1 of the interrupt-enable register (write select 3), as they stood before the previous edge. It therefore lags them by one cycle.
- R6: A write to select 4 with only bit 0 set has no effect on the flag.
- R7: When a clear write and a setting code fall on the same edge, the flag reads 1.
- R8: Writes to select 0 and select 1 load the floor and the ceiling from the write data. A code that arrives on the same edge as a limit write is judged against the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_code | input | CODE_W | Finished temperature code |
| res_vld | input | 1 | One-cycle strobe marking a new code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 floor, 1 ceiling, 2 mode, 3 interrupt enable, 4 clear |
| wr_data | input | CODE_W | Write data |
| cmp_flag | output | 1 | Sticky out-of-band flag |
| cmp_irq | output | 1 | Registered interrupt line |

## Verification
Codes are fed in from inside the band, from exactly on each limit, and from one step beyond each limit. This separates strict from inclusive comparison and shows which side of the band is tested. The same outside code is also sent with the strobe low and with comparison disabled, which shows that both gates work. Clear writes are made with only the conversion bit, with only the compare bit, and together with a setting code, which shows which bit clears and which action wins. A limit is rewritten on the same edge as a code arrives, which shows whether the old or the new limit is used.

// File: rtl/thermwin_pkg.sv
package thermwin_pkg;
  typedef enum logic [2:0] {
    SEL_LOW  = 3'd0,
    SEL_HIGH = 3'd1,
    SEL_MODE = 3'd2,
    SEL_IEN  = 3'd3,
    SEL_CLR  = 3'd4
  } wsel_e;

  localparam int MODE_EN_BIT  = 0;
  localparam int IEN_CMP_BIT  = 1;
  localparam int CLR_CMP_BIT  = 1;
endpackage

// File: rtl/thermwin_regs.sv
module thermwin_regs
  import thermwin_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] lim_lo,
  output logic [CODE_W-1:0] lim_hi,
  output logic              cmp_en,
  output logic              irq_en,
  output logic              clr_cmp
);
  logic [CODE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              en_q, en_d, ie_q, ie_d;
  wsel_e             sel;

  assign sel = wsel_e'(wr_sel);

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    en_d    = en_q;
    ie_d    = ie_q;
    clr_cmp = 1'b0;
    if (wr_en) begin
      case (sel)
        SEL_LOW:  lo_d    = wr_data;
        SEL_HIGH: hi_d    = wr_data;
        SEL_MODE: en_d    = wr_data[MODE_EN_BIT];
        SEL_IEN:  ie_d    = wr_data[IEN_CMP_BIT];
        SEL_CLR:  clr_cmp = wr_data[CLR_CMP_BIT];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '1;
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      en_q <= en_d;
      ie_q <= ie_d;
    end
  end

  assign lim_lo = lo_q;
  assign lim_hi = hi_q;
  assign cmp_en = en_q;
  assign irq_en = ie_q;

  // R8
  lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd0) |=> $stable(lim_lo));
endmodule

// File: rtl/thermwin_window.sv
module thermwin_window #(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] lim_lo,
  input  logic [CODE_W-1:0] lim_hi,
  output logic              outside
);
  logic below, above;

  always_comb begin
    below   = code < lim_lo;
    above   = code > lim_hi;
    outside = below | above;
  end
endmodule

// File: rtl/thermwin_flag.sv
module thermwin_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d, irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_req) flag_d = 1'b0;
    if (set_req) flag_d = 1'b1;
    irq_d = flag_q & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> flag);
  // R5
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && irq_en) |=> irq);
  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag && irq_en) |=> !irq);
endmodule

// File: rtl/thermwin_top.sv
module thermwin_top #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] res_code,
  input  logic              res_vld,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  output logic              cmp_flag,
  output logic              cmp_irq
);
  logic [CODE_W-1:0] lim_lo, lim_hi;
  logic              cmp_en, irq_en, clr_cmp, outside, set_req;

  thermwin_regs #(.CODE_W(CODE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lim_lo  (lim_lo),
    .lim_hi  (lim_hi),
    .cmp_en  (cmp_en),
    .irq_en  (irq_en),
    .clr_cmp (clr_cmp)
  );

  thermwin_window #(.CODE_W(CODE_W)) u_window (
    .code    (res_code),
    .lim_lo  (lim_lo),
    .lim_hi  (lim_hi),
    .outside (outside)
  );

  assign set_req = res_vld & cmp_en & outside;

  thermwin_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .clr_req (clr_cmp),
    .irq_en  (irq_en),
    .flag    (cmp_flag),
    .irq     (cmp_irq)
  );

  // R3
  set_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(res_vld && cmp_en));
  // R2
  set_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(res_code < lim_lo || res_code > lim_hi));
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmp && !(res_vld && cmp_en && outside)) |=> !cmp_flag);
endmodule

// File: tb/thermwin_top_test.sv
module thermwin_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] res_code = '0;
  logic         res_vld = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         cmp_flag, cmp_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_lo, m_hi, m_en, m_ie, m_flag, m_irq;

  thermwin_top #(.CODE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .res_code(res_code), .res_vld(res_vld),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 4095; m_en = 0; m_ie = 0; m_flag = 0; m_irq = 0;
    end else begin
      int nf;
      nf = m_flag;
      if (wr_en && wr_sel == 3'd4 && wr_data[1]) nf = 0;
      if (res_vld && m_en != 0 && (int'(res_code) < m_lo || int'(res_code) > m_hi)) nf = 1;
      m_irq = (m_flag != 0 && m_ie != 0) ? 1 : 0;
      m_flag = nf;
      if (wr_en) begin
        case (wr_sel)
          3'd0: m_lo = int'(wr_data);
          3'd1: m_hi = int'(wr_data);
          3'd2: m_en = int'(wr_data[0]);
          3'd3: m_ie = int'(wr_data[1]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model flag", int'(cmp_flag), m_flag);
      check("R5 model irq", int'(cmp_irq), m_irq);
    end
  end

  task automatic cyc(bit w, int sel, int data, bit v, int code);
    wr_en = w; wr_sel = 3'(sel); wr_data = W'(data);
    res_vld = v; res_code = W'(code);
    @(negedge clk);
    wr_en = 0; res_vld = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flag", int'(cmp_flag), 0);
    check("R1 reset irq", int'(cmp_irq), 0);
    rst_n = 1;
    @(negedge clk);
    cyc(0, 0, 0, 1, 4095);
    check("R3 disabled after reset", int'(cmp_flag), 0);
    cyc(1, 2, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 4095);
    check("R1 default band covers all codes", int'(cmp_flag), 0);
    cyc(1, 0, 100, 0, 0);
    cyc(1, 1, 200, 0, 0);
    cyc(0, 0, 0, 1, 150);
    cyc(0, 0, 0, 1, 100);
    cyc(0, 0, 0, 1, 200);
    check("R2 limits inclusive", int'(cmp_flag), 0);
    cyc(0, 0, 0, 1, 99);
    check("R2 below floor", int'(cmp_flag), 1);
    check("R5 irq masked", int'(cmp_irq), 0);
    cyc(1, 4, 1, 0, 0);
    check("R6 conversion clear bit", int'(cmp_flag), 1);
    cyc(1, 3, 2, 0, 0);
    check("R5 irq lag", int'(cmp_irq), 0);
    cyc(0, 0, 0, 0, 0);
    check("R5 irq raised", int'(cmp_irq), 1);
    cyc(1, 4, 2, 0, 0);
    check("R4 cleared", int'(cmp_flag), 0);
    check("R5 irq still old", int'(cmp_irq), 1);
    cyc(0, 0, 0, 0, 0);
    check("R5 irq dropped", int'(cmp_irq), 0);
    cyc(0, 0, 0, 1, 201);
    check("R2 above ceiling", int'(cmp_flag), 1);
    repeat (3) cyc(0, 0, 0, 0, 0);
    check("R4 sticky", int'(cmp_flag), 1);
    cyc(1, 4, 3, 1, 250);
    check("R7 set wins", int'(cmp_flag), 1);
    cyc(1, 4, 3, 0, 0);
    check("R4 clear both bits", int'(cmp_flag), 0);
    cyc(1, 2, 0, 0, 0);
    cyc(0, 0, 0, 1, 5);
    check("R3 compare off", int'(cmp_flag), 0);
    cyc(1, 2, 1, 0, 0);
    cyc(0, 0, 0, 0, 5);
    check("R3 no strobe", int'(cmp_flag), 0);
    cyc(1, 0, 10, 1, 50);
    check("R8 old floor used", int'(cmp_flag), 1);
    cyc(1, 4, 2, 0, 0);
    cyc(0, 0, 0, 1, 50);
    check("R8 new floor used", int'(cmp_flag), 0);
    cyc(1, 3, 0, 0, 0);
    cyc(0, 0, 0, 1, 4000);
    cyc(0, 0, 0, 0, 0);
    check("R5 irq disabled", int'(cmp_irq), 0);
    check("R2 flag set with irq off", int'(cmp_flag), 1);
    finish_run();
  end
endmodule